// File: doc/BRIEF.md
# Fan Speed PWM Generator with Sleep Hysteresis

This block turns a digital speed-control code into the high-side drive waveform for a two-phase brushless fan driver. A counter produces a triangle carrier that climbs from a floor code to a ceiling code and then descends back at the same rate. The carrier is compared against a clamped copy of the control code, so the high-side on-time is a linear map of the offset range between floor and ceiling. A synchronous low-side switch enable fills the off-time. It is kept apart from the high-side pulse by a guard gap of a few clocks on each side.

A two-state machine decides whether the fan is asleep or running. Leaving sleep needs a code strictly above a start threshold. Once running, the code can fall to the sleep threshold itself without stopping the drive, so a fan that has overcome stiction can run slower than it could start. A thermal fault forces both switches off. A charge-pump undervoltage flag holds only the high side off. The run flag is exported so that phase commutation logic elsewhere can gate its own enables, and a single-clock tick at each carrier valley serves downstream timers.

With the default 8-bit code, 255 stands for about 2.5 V. The floor is 51, the ceiling 235, the sleep threshold 72 and the start threshold 82. `STEP_DIV` slows the carrier so that a real system clock gives a carrier near 23 kHz.

Top module: `fanPwmCore`

## Requirements
- R1: The carrier moves one code per step, rising from FLOOR to CEIL and falling back, with equal rise and fall. One period is 2·(CEIL−FLOOR)·STEP_DIV clocks. `valleyTick` is high for exactly one clock per period, at the floor.
- R2: With a constant code c, let k = min(max(c,FLOOR),CEIL) − FLOOR. `hsEn` is then high for exactly 2k clocks of every 2·(CEIL−FLOOR) period. Codes at or above CEIL give 100 %, and codes at or below FLOOR give 0 %.
- R3: The duty-setting code is captured only at the step that reaches a peak or a valley. A code change in the middle of a half-period leaves the rest of that half unchanged.
- R4: After reset the block is asleep: `runFlag`, `hsEn` and `syncEn` are 0.
- R5: From sleep, `runFlag` rises one clock after `ctrlCode` > START_TH. A code from SLEEP_TH up to START_TH inclusive keeps the block asleep with both enables low.
- R6: While running, a code equal to SLEEP_TH keeps the block running. A code below SLEEP_TH drops `runFlag` on the next clock, and `hsEn` and `syncEn` stay low while asleep.
- R7: While `cpUnderVolt` is 1, `hsEn` is 0. In the run state without a thermal fault, `syncEn` then stays on once the guard gap has passed.
- R8: While `thermalFault` is 1, both `hsEn` and `syncEn` are 0. The sleep/run state is unaffected, and drive resumes when the fault clears.
- R9: `hsEn` and `syncEn` are never high together. `syncEn` stays low for DEAD clocks before every rise and after every fall of `hsEn`. With 0 < 2k < 2·(CEIL−FLOOR), `syncEn` is high for 2·(CEIL−FLOOR)−2k−2·DEAD clocks per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlCode | input | CODE_W | Speed-control code (full scale ≈ 2.5 V) |
| thermalFault | input | 1 | Die over-temperature flag |
| cpUnderVolt | input | 1 | Charge-pump undervoltage flag |
| hsEn | output | 1 | High-side switch enable |
| syncEn | output | 1 | Synchronous low-side switch enable |
| runFlag | output | 1 | 1 in run state, 0 in sleep |
| valleyTick | output | 1 | One-clock pulse at each carrier valley |

## Verification
A carrier counter that skips or repeats a code shows up as a changed tick spacing within one period, and as an on-time count that is off by one or two. A wrong compare at a turnaround shows the same way. A corrupted run state is visible within one clock on `runFlag`, and within the guard delay on both enables. A broken guard history either overlaps the two enables on the very next edge or shortens the `syncEn` count by a few clocks in the first measured period. A code captured at the wrong moment changes `hsEn` within a few clocks of a mid-half-period code change.

// File: rtl/fanPwmPkg.sv
package fanPwmPkg;

  // Strobes from the control FSM to the carrier datapath.
  typedef struct packed {
    logic sampleNow;    // capture new duty code on this step
    logic hsAllowed;    // high side may switch on
    logic syncAllowed;  // synchronous low side may switch on
  } pwmStrobe_t;

  typedef enum logic {
    ST_SLEEP = 1'b0,
    ST_RUN   = 1'b1
  } runState_t;

endpackage

// File: rtl/fanPwmCtrl.sv
module fanPwmCtrl
  import fanPwmPkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int SLEEP_TH = 72,
  parameter int START_TH = 82
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] ctrlCode,
  input  logic              thermalFault,
  input  logic              cpUnderVolt,
  input  logic              turnNext,
  output pwmStrobe_t        strobe,
  output logic              runFlag
);

  localparam logic [CODE_W-1:0] SLEEP_C = CODE_W'(SLEEP_TH);
  localparam logic [CODE_W-1:0] START_C = CODE_W'(START_TH);

  runState_t state, stateNext;

  // Hysteresis: wake strictly above start, drop strictly below sleep.
  always_comb begin
    stateNext = state;
    unique case (state)
      ST_SLEEP: if (ctrlCode > START_C) stateNext = ST_RUN;
      ST_RUN:   if (ctrlCode < SLEEP_C) stateNext = ST_SLEEP;
      default:  stateNext = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SLEEP;
    else       state <= stateNext;
  end

  logic driveOk;
  assign driveOk = (state == ST_RUN) && !thermalFault;

  always_comb begin
    strobe.sampleNow   = turnNext;
    strobe.hsAllowed   = driveOk && !cpUnderVolt;
    strobe.syncAllowed = driveOk;
  end

  assign runFlag = (state == ST_RUN);

endmodule

// File: rtl/fanPwmDatapath.sv
module fanPwmDatapath
  import fanPwmPkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int FLOOR    = 51,
  parameter int CEIL     = 235,
  parameter int STEP_DIV = 1,
  parameter int DEAD     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] ctrlCode,
  input  pwmStrobe_t        strobe,
  output logic              turnNext,
  output logic              valleyTick,
  output logic              hsEn,
  output logic              syncEn
);

  localparam logic [CODE_W-1:0] FLOOR_C = CODE_W'(FLOOR);
  localparam logic [CODE_W-1:0] CEIL_C  = CODE_W'(CEIL);
  localparam logic [CODE_W-1:0] CEIL_M1 = CODE_W'(CEIL - 1);
  localparam logic [CODE_W-1:0] FLOOR_P1 = CODE_W'(FLOOR + 1);
  localparam int DIV_W  = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam int HIST_W = 2 * DEAD + 1;

  // ---------------- carrier step enable ----------------
  logic stepEn;
  generate
    if (STEP_DIV == 1) begin : gNoDiv
      assign stepEn = 1'b1;
    end else begin : gDiv
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                               divCnt <= '0;
        else if (divCnt == DIV_W'(STEP_DIV - 1)) divCnt <= '0;
        else                                     divCnt <= divCnt + 1'b1;
      end
      assign stepEn = (divCnt == DIV_W'(STEP_DIV - 1));
    end
  endgenerate

  // ---------------- triangle carrier ----------------
  // dirUp=1 holds values FLOOR..CEIL-1, dirUp=0 holds CEIL..FLOOR+1.
  logic [CODE_W-1:0] carrier;
  logic              dirUp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carrier <= FLOOR_C;
      dirUp   <= 1'b1;
    end else if (stepEn) begin
      if (dirUp) begin
        carrier <= carrier + 1'b1;
        if (carrier == CEIL_M1) dirUp <= 1'b0;
      end else begin
        carrier <= carrier - 1'b1;
        if (carrier == FLOOR_P1) dirUp <= 1'b1;
      end
    end
  end

  assign turnNext   = stepEn && (dirUp ? (carrier == CEIL_M1) : (carrier == FLOOR_P1));
  assign valleyTick = stepEn && dirUp && (carrier == FLOOR_C);

  // ---------------- duty code capture ----------------
  logic [CODE_W-1:0] codeClamped, dutyCode;
  always_comb begin
    if (ctrlCode < FLOOR_C)     codeClamped = FLOOR_C;
    else if (ctrlCode > CEIL_C) codeClamped = CEIL_C;
    else                        codeClamped = ctrlCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 dutyCode <= FLOOR_C;
    else if (strobe.sampleNow) dutyCode <= codeClamped;
  end

  // Strict compare while rising, inclusive while falling: 2k on-steps per period.
  logic pwmRaw;
  assign pwmRaw = strobe.hsAllowed &&
                  (dirUp ? (carrier < dutyCode) : (carrier <= dutyCode));

  // ---------------- non-overlap window ----------------
  logic [HIST_W-1:0] hist;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hist <= '0;
    else       hist <= {hist[HIST_W-2:0], pwmRaw};
  end

  assign hsEn   = hist[DEAD] && strobe.hsAllowed;
  assign syncEn = (hist == '0) && strobe.syncAllowed;

endmodule

// File: rtl/fanPwmCore.sv
module fanPwmCore
  import fanPwmPkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int FLOOR    = 51,
  parameter int CEIL     = 235,
  parameter int SLEEP_TH = 72,
  parameter int START_TH = 82,
  parameter int STEP_DIV = 1,
  parameter int DEAD     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] ctrlCode,
  input  logic              thermalFault,
  input  logic              cpUnderVolt,
  output logic              hsEn,
  output logic              syncEn,
  output logic              runFlag,
  output logic              valleyTick
);

  pwmStrobe_t strobe;
  logic       turnNext;

  fanPwmCtrl #(
    .CODE_W(CODE_W), .SLEEP_TH(SLEEP_TH), .START_TH(START_TH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlCode(ctrlCode),
    .thermalFault(thermalFault), .cpUnderVolt(cpUnderVolt),
    .turnNext(turnNext), .strobe(strobe), .runFlag(runFlag)
  );

  fanPwmDatapath #(
    .CODE_W(CODE_W), .FLOOR(FLOOR), .CEIL(CEIL),
    .STEP_DIV(STEP_DIV), .DEAD(DEAD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrlCode(ctrlCode), .strobe(strobe),
    .turnNext(turnNext), .valleyTick(valleyTick),
    .hsEn(hsEn), .syncEn(syncEn)
  );

endmodule

// File: rtl/fanPwmCoreChk.sv
module fanPwmCoreChk #(
  parameter int CODE_W   = 8,
  parameter int SLEEP_TH = 72,
  parameter int START_TH = 82
) (
  input logic              clk,
  input logic              rstN,
  input logic [CODE_W-1:0] ctrlCode,
  input logic              thermalFault,
  input logic              cpUnderVolt,
  input logic              hsEn,
  input logic              syncEn,
  input logic              runFlag,
  input logic              valleyTick
);

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(hsEn && syncEn));

  a_r9_gap_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hsEn) |=> !syncEn);

  a_r6_sleep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !runFlag |-> (!hsEn && !syncEn));

  a_r7_uv_holds_high_side: assert property (@(posedge clk) disable iff (!rstN)
    cpUnderVolt |-> !hsEn);

  a_r8_thermal_off: assert property (@(posedge clk) disable iff (!rstN)
    thermalFault |-> (!hsEn && !syncEn));

  a_r5_wake_above_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runFlag) |-> ($past(ctrlCode) > CODE_W'(START_TH)));

  a_r6_sleep_below_threshold: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runFlag) |-> ($past(ctrlCode) < CODE_W'(SLEEP_TH)));

  a_r1_tick_single: assert property (@(posedge clk) disable iff (!rstN)
    valleyTick |=> !valleyTick);

endmodule

bind fanPwmCore fanPwmCoreChk #(
  .CODE_W(CODE_W), .SLEEP_TH(SLEEP_TH), .START_TH(START_TH)
) u_chk (
  .clk(clk), .rstN(rstN), .ctrlCode(ctrlCode),
  .thermalFault(thermalFault), .cpUnderVolt(cpUnderVolt),
  .hsEn(hsEn), .syncEn(syncEn), .runFlag(runFlag), .valleyTick(valleyTick)
);

// File: tb/fanPwmCore_tb.sv
module fanPwmCore_tb;

  localparam int CODE_W = 8;
  localparam int FLOOR  = 51;
  localparam int CEIL   = 235;
  localparam int DEAD   = 2;
  localparam int PERIOD = 2 * (CEIL - FLOOR);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [CODE_W-1:0] ctrlCode = '0;
  logic              thermalFault = 1'b0;
  logic              cpUnderVolt = 1'b0;
  logic              hsEn, syncEn, runFlag, valleyTick;

  int nChecks = 0;
  int nFail   = 0;
  int hsCnt, syncCnt, overlapCnt;

  always #2 clk = ~clk;

  fanPwmCore u_dut (
    .clk(clk), .rstN(rstN), .ctrlCode(ctrlCode),
    .thermalFault(thermalFault), .cpUnderVolt(cpUnderVolt),
    .hsEn(hsEn), .syncEn(syncEn), .runFlag(runFlag), .valleyTick(valleyTick)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int dutyOn(input int code);
    int c = code < FLOOR ? FLOOR : (code > CEIL ? CEIL : code);
    return 2 * (c - FLOOR);
  endfunction

  task automatic waitTick();
    do @(negedge clk); while (!valleyTick);
  endtask

  // Settle two periods, then count enables over one full period.
  task automatic measure();
    waitTick(); waitTick();
    hsCnt = 0; syncCnt = 0; overlapCnt = 0;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      hsCnt      += hsEn;
      syncCnt    += syncEn;
      overlapCnt += (hsEn && syncEn);
    end
  endtask

  task automatic setCode(input int code);
    @(negedge clk); ctrlCode = CODE_W'(code);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R4 runFlag after reset", runFlag, 0);
    check("R4 hsEn after reset", hsEn, 0);
    check("R4 syncEn after reset", syncEn, 0);
  endtask

  task automatic testTickPeriod();
    int gap = 0;
    waitTick();
    do begin @(negedge clk); gap++; end while (!valleyTick);
    check("R1 valley tick spacing", gap, PERIOD);
  endtask

  task automatic testNoWakeBetween();
    setCode(82);
    measure();
    check("R5 asleep at start threshold", runFlag, 0);
    check("R5 no high side asleep", hsCnt, 0);
    check("R5 no sync asleep", syncCnt, 0);
  endtask

  task automatic testWake();
    setCode(83);
    @(negedge clk);
    check("R5 wake one clock after code above start", runFlag, 1);
    measure();
    check("R2 duty at code 83", hsCnt, dutyOn(83));
    check("R9 sync count at code 83", syncCnt, PERIOD - dutyOn(83) - 2 * DEAD);
    check("R9 no overlap", overlapCnt, 0);
  endtask

  task automatic testHoldAtSleep();
    setCode(72);
    measure();
    check("R6 run held at sleep threshold", runFlag, 1);
    check("R2 duty at code 72", hsCnt, dutyOn(72));
  endtask

  task automatic testSleep();
    setCode(71);
    @(negedge clk);
    check("R6 sleep one clock after code below threshold", runFlag, 0);
    measure();
    check("R6 high side off asleep", hsCnt, 0);
    check("R6 sync off asleep", syncCnt, 0);
  endtask

  task automatic testMidDuty();
    setCode(200);
    measure();
    check("R2 duty at code 200", hsCnt, dutyOn(200));
    check("R9 sync count at code 200", syncCnt, PERIOD - dutyOn(200) - 2 * DEAD);
    check("R9 no overlap at 200", overlapCnt, 0);
  endtask

  task automatic testFull();
    setCode(235);
    measure();
    check("R2 full duty at ceiling", hsCnt, PERIOD);
    check("R2 no sync at full duty", syncCnt, 0);
    setCode(255);
    measure();
    check("R2 clamp above ceiling", hsCnt, PERIOD);
  endtask

  task automatic testMidHalfChange();
    setCode(200);
    measure();
    waitTick();
    repeat (60) @(negedge clk);
    ctrlCode = CODE_W'(100);
    repeat (20) @(negedge clk);
    check("R3 rising half keeps old duty code", hsEn, 1);
    measure();
    check("R3 new duty after turnaround", hsCnt, dutyOn(100));
  endtask

  task automatic testUnderVolt();
    setCode(150);
    cpUnderVolt = 1'b1;
    measure();
    check("R7 high side held off", hsCnt, 0);
    check("R7 sync fills period", syncCnt, PERIOD);
    check("R7 still running", runFlag, 1);
    @(negedge clk); cpUnderVolt = 1'b0;
    measure();
    check("R7 drive back after undervoltage", hsCnt, dutyOn(150));
  endtask

  task automatic testThermal();
    setCode(150);
    thermalFault = 1'b1;
    measure();
    check("R8 high side off on fault", hsCnt, 0);
    check("R8 sync off on fault", syncCnt, 0);
    check("R8 run state kept", runFlag, 1);
    @(negedge clk); thermalFault = 1'b0;
    measure();
    check("R8 drive back after fault", hsCnt, dutyOn(150));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTickPeriod();
    testNoWakeBetween();
    testWake();
    testHoldAtSleep();
    testSleep();
    testMidDuty();
    testFull();
    testMidHalfChange();
    testUnderVolt();
    testThermal();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule